// File: doc/BRIEF.md
# Clock-Frequency Watchdog with Safe-Code Recovery

This block supervises the frequency-selection state of a programmable clock synthesizer. Software arms it with a down-count depth measured in ticks of a slow time base (one tick is nominally 250 ms). While the count runs, the same depth field reads back the live count. If software does not re-arm or disarm the watchdog before the count is used up, the block assumes the current frequency setting has hung the system and recovers. It pulls an active-low system reset for a fixed number of ticks. It sets a sticky timeout flag. It cancels the software M/N override. It also rewrites the frequency-select code with a known-good value: either the code latched from the strap pins at power-up, or a separately programmed safe code.

The effective 5-bit frequency code that drives the synthesizer table comes from the software select register when software selection is enabled, and from the strap-latched code otherwise. The PLL and its frequency table are outside this block.

Top module: `wdog_freq_guard`

## Requirements
- R1: After synchronous reset, `sys_rst_n_o` is 1, `running_o` is 0, `timeout_o` is 0, `mn_en_o` is 0, and `freq_code_o` equals `strap_fs_i` because software selection is off.
- R2: A write of the enable bit with value 1 (`en_wr_i`=1, `en_wdata_i`=1) loads the counter from `depth_i`, sets `running_o` and clears `timeout_o` by the next clock cycle.
- R3: `count_o` returns the present down-count while `running_o` is 1, and returns `depth_i` while it is 0.
- R4: Each `tick_i` pulse while running lowers the count by one. The watchdog expires on the tick that finds a count of 1 or 0, so depth N expires on tick N and depth 0 expires on the first tick.
- R5: On expiry `running_o` drops to 0 and `timeout_o` rises to 1. `timeout_o` then stays at 1 until the next arming write.
- R6: `sys_rst_n_o` is driven to 0 from the cycle after expiry until the PULSE_TICKS-th later tick, and returns to 1 in the cycle after that tick. A re-arming write during the pulse neither shortens nor extends it.
- R7: On expiry, `mn_en_o` is cleared, software selection is enabled, and the select code becomes `safe_code_i` when `safe_sel_i` is 1, or `strap_fs_i` when it is 0.
- R8: `freq_code_o` equals the software select code when software selection is enabled, and `strap_fs_i` otherwise. A configuration write (`cfg_wr_i`) loads the software select code, the software select enable and `mn_en_o`.
- R9: A write of the enable bit with value 0 stops the count with no reset pulse and no change to `timeout_o`. Later ticks have no effect.
- R10: An arming write in the same cycle as a tick takes precedence over the tick. Recovery on expiry takes precedence over a configuration write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per watchdog time unit |
| en_wr_i | input | 1 | Strobe for a write of the enable bit |
| en_wdata_i | input | 1 | Enable bit value: 1 arms, 0 disarms |
| depth_i | input | 7 | Programmed down-count depth in ticks |
| strap_fs_i | input | 5 | Frequency code latched from strap pins at power-up |
| safe_code_i | input | 5 | Programmed safe frequency code |
| safe_sel_i | input | 1 | 1: recover to safe code, 0: recover to strap code |
| cfg_wr_i | input | 1 | Strobe for a frequency configuration write |
| cfg_ssel_i | input | 5 | Software frequency select code |
| cfg_sw_en_i | input | 1 | Software select enable |
| cfg_mn_en_i | input | 1 | Step-less M/N override enable |
| sys_rst_n_o | output | 1 | Active-low system reset pulse |
| count_o | output | 7 | Depth / live down-count readback |
| running_o | output | 1 | Enable readback: 1 while counting |
| timeout_o | output | 1 | Sticky timeout flag |
| mn_en_o | output | 1 | Step-less M/N override enable |
| freq_code_o | output | 5 | Effective frequency code |

## Verification
On every cycle the assertions check the local cycle-to-cycle rules. These are the per-tick decrement, the counter load on arming, the stop on expiry, reset asserting right after a start, the M/N override clearing on recovery, and the timeout flag holding between arming writes. Other behaviour needs whole scenarios that only the bench drives. That covers the pulse length counted in ticks, its survival across a re-arm, and the recovered frequency code under both safe-select settings. It also covers the readback switching between count and depth, the precedence rules, and the immediate expiry at depth 0.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    parameter int DEPTH_W = 7;
    parameter int FS_W    = 5;

    typedef struct packed {
        logic            sw_en;
        logic            mn_en;
        logic [FS_W-1:0] ssel;
    } freq_cfg_t;

    typedef enum logic [1:0] {
        WD_CMD_NONE   = 2'd0,
        WD_CMD_ARM    = 2'd1,
        WD_CMD_DISARM = 2'd2
    } wd_cmd_e;

    function automatic wd_cmd_e decode_cmd(input logic wr, input logic val);
        if (!wr)      return WD_CMD_NONE;
        else if (val) return WD_CMD_ARM;
        else          return WD_CMD_DISARM;
    endfunction

    function automatic logic [FS_W-1:0] pick_code(
        input logic            sw_en,
        input logic [FS_W-1:0] sw_code,
        input logic [FS_W-1:0] hw_code
    );
        return sw_en ? sw_code : hw_code;
    endfunction

endpackage

// File: rtl/wdg_down_counter.sv
module wdg_down_counter
    import wdg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  wd_cmd_e            cmd,
    input  logic [DEPTH_W-1:0] depth,
    output logic [DEPTH_W-1:0] count,
    output logic               running,
    output logic               expire
);

    localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);

    // expiry only when no enable write competes in this cycle
    assign expire = running && tick && (cmd == WD_CMD_NONE) && (count <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
        end else if (cmd == WD_CMD_ARM) begin
            count   <= depth;
            running <= 1'b1;
        end else if (cmd == WD_CMD_DISARM) begin
            running <= 1'b0;
        end else if (expire) begin
            count   <= '0;
            running <= 1'b0;
        end else if (running && tick) begin
            count   <= count - ONE;
        end
    end

    AST_CNT_DECR: assert property (@(posedge clk) disable iff (rst)
        (running && tick && cmd == WD_CMD_NONE && count > ONE) |=> (count == $past(count) - ONE)) // R4
        else $error("count did not step down");

    AST_ARM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmd == WD_CMD_ARM) |=> (running && count == $past(depth))) // R2
        else $error("arm did not load depth");

    AST_EXPIRE_STOP: assert property (@(posedge clk) disable iff (rst)
        expire |=> !running) // R5
        else $error("still running after expiry");

endmodule

// File: rtl/wdg_reset_pulse.sv
module wdg_reset_pulse #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    output logic rst_n
);

    localparam int PW = $clog2(PULSE_TICKS + 1);
    localparam logic [PW-1:0] LOAD = PW'(PULSE_TICKS);

    logic [PW-1:0] remain;
    logic          active;

    assign active = (remain != '0);
    assign rst_n  = !active;

    always_ff @(posedge clk) begin
        if (rst)                 remain <= '0;
        else if (start)          remain <= LOAD;
        else if (active && tick) remain <= remain - PW'(1);
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        start |=> !rst_n) // R6
        else $error("reset pulse did not start");

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst_n && !tick) |=> !rst_n) // R6
        else $error("reset pulse ended without a tick");

endmodule

// File: rtl/wdg_freq_select.sv
module wdg_freq_select
    import wdg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            recover,
    input  logic [FS_W-1:0] strap_fs,
    input  logic [FS_W-1:0] safe_code,
    input  logic            safe_sel,
    input  logic            cfg_wr,
    input  freq_cfg_t       cfg_new,
    output logic            mn_en,
    output logic [FS_W-1:0] freq_code
);

    freq_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (recover) begin
            cfg_q.sw_en <= 1'b1;
            cfg_q.mn_en <= 1'b0;
            cfg_q.ssel  <= safe_sel ? safe_code : strap_fs;
        end else if (cfg_wr) begin
            cfg_q <= cfg_new;
        end
    end

    assign mn_en     = cfg_q.mn_en;
    assign freq_code = pick_code(cfg_q.sw_en, cfg_q.ssel, strap_fs);

    AST_RECOVER_MN: assert property (@(posedge clk) disable iff (rst)
        recover |=> !mn_en) // R7
        else $error("M/N override survived recovery");

endmodule

// File: rtl/wdog_freq_guard.sv
module wdog_freq_guard
    import wdg_pkg::*;
#(
    parameter int PULSE_TICKS = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               en_wr_i,
    input  logic               en_wdata_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic [FS_W-1:0]    strap_fs_i,
    input  logic [FS_W-1:0]    safe_code_i,
    input  logic               safe_sel_i,
    input  logic               cfg_wr_i,
    input  logic [FS_W-1:0]    cfg_ssel_i,
    input  logic               cfg_sw_en_i,
    input  logic               cfg_mn_en_i,
    output logic               sys_rst_n_o,
    output logic [DEPTH_W-1:0] count_o,
    output logic               running_o,
    output logic               timeout_o,
    output logic               mn_en_o,
    output logic [FS_W-1:0]    freq_code_o
);

    wd_cmd_e            cmd;
    logic [DEPTH_W-1:0] cnt;
    logic               run;
    logic               expire;
    logic               flag_q;
    freq_cfg_t          cfg_new;

    assign cmd = decode_cmd(en_wr_i, en_wdata_i);

    wdg_down_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_i),
        .cmd     (cmd),
        .depth   (depth_i),
        .count   (cnt),
        .running (run),
        .expire  (expire)
    );

    wdg_reset_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_i),
        .start (expire),
        .rst_n (sys_rst_n_o)
    );

    always_comb begin
        cfg_new.sw_en = cfg_sw_en_i;
        cfg_new.mn_en = cfg_mn_en_i;
        cfg_new.ssel  = cfg_ssel_i;
    end

    wdg_freq_select u_fsel (
        .clk       (clk),
        .rst       (rst),
        .recover   (expire),
        .strap_fs  (strap_fs_i),
        .safe_code (safe_code_i),
        .safe_sel  (safe_sel_i),
        .cfg_wr    (cfg_wr_i),
        .cfg_new   (cfg_new),
        .mn_en     (mn_en_o),
        .freq_code (freq_code_o)
    );

    always_ff @(posedge clk) begin
        if (rst)                     flag_q <= 1'b0;
        else if (cmd == WD_CMD_ARM)  flag_q <= 1'b0;
        else if (expire)             flag_q <= 1'b1;
    end

    assign timeout_o = flag_q;
    assign running_o = run;
    assign count_o   = run ? cnt : depth_i;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (timeout_o && cmd != WD_CMD_ARM) |=> timeout_o) // R5
        else $error("timeout flag lost");

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd == WD_CMD_ARM) |=> !timeout_o) // R2
        else $error("timeout flag not cleared on arm");

endmodule

// File: tb/wdog_freq_guard_tb_top.sv
module wdog_freq_guard_tb_top;

    localparam int PT = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0, en_wr_i = 1'b0, en_wdata_i = 1'b0;
    logic [6:0] depth_i = 7'd8;
    logic [4:0] strap_fs_i = 5'd3, safe_code_i = 5'd9;
    logic       safe_sel_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [4:0] cfg_ssel_i = '0;
    logic       cfg_sw_en_i = 1'b0, cfg_mn_en_i = 1'b0;
    logic       sys_rst_n_o, running_o, timeout_o, mn_en_o;
    logic [6:0] count_o;
    logic [4:0] freq_code_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wdog_freq_guard #(.PULSE_TICKS(PT)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic en_write(input logic v);
        @(negedge clk) begin en_wr_i = 1'b1; en_wdata_i = v; end
        @(negedge clk) en_wr_i = 1'b0;
    endtask

    task automatic cfg_write(input logic [4:0] s, input logic sw, input logic mn);
        @(negedge clk) begin cfg_wr_i = 1'b1; cfg_ssel_i = s; cfg_sw_en_i = sw; cfg_mn_en_i = mn; end
        @(negedge clk) cfg_wr_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rst_n", sys_rst_n_o, 1);
        chk("R1 running", running_o, 0);
        chk("R1 timeout", timeout_o, 0);
        chk("R1 mn_en", mn_en_o, 0);
        chk("R1 freq", freq_code_o, 3);
        chk("R3 idle readback", count_o, 8);

        // sweep depths and both recovery sources
        for (int d = 0; d < 10; d++) begin
            automatic int e_ticks = (d == 0) ? 1 : d;
            automatic int exp_code;
            depth_i     = 7'(d);
            strap_fs_i  = 5'(d + 3);
            safe_code_i = 5'(31 - d);
            safe_sel_i  = d[0];
            exp_code    = d[0] ? (31 - d) : (d + 3);
            cfg_write(5'(20 + d), 1'b1, 1'b1);
            chk("R8 sw code", freq_code_o, 20 + d);
            chk("R8 mn_en", mn_en_o, 1);
            en_write(1'b1);
            chk("R2 running", running_o, 1);
            chk("R2 timeout clear", timeout_o, 0);
            chk("R3 live count", count_o, d);
            for (int k = 1; k < e_ticks; k++) begin
                tick_once();
                chk("R4 count step", count_o, d - k);
                chk("R4 running", running_o, 1);
                chk("R6 no pulse", sys_rst_n_o, 1);
            end
            tick_once();
            chk("R5 stopped", running_o, 0);
            chk("R5 timeout", timeout_o, 1);
            chk("R6 pulse low", sys_rst_n_o, 0);
            chk("R7 mn cleared", mn_en_o, 0);
            chk("R7 recovered code", freq_code_o, exp_code);
            chk("R3 readback depth", count_o, d);
            for (int p = 1; p < PT; p++) begin
                tick_once();
                chk("R6 pulse held", sys_rst_n_o, 0);
            end
            tick_once();
            chk("R6 pulse end", sys_rst_n_o, 1);
            chk("R5 sticky", timeout_o, 1);
        end

        // R8 hardware selection when software select is off
        strap_fs_i = 5'd17;
        cfg_write(5'd4, 1'b0, 1'b0);
        chk("R8 hw code", freq_code_o, 17);

        // R6 re-arm during pulse
        depth_i = 7'd1;
        en_write(1'b1);
        tick_once();
        chk("R6 pulse start", sys_rst_n_o, 0);
        depth_i = 7'd5;
        en_write(1'b1);
        chk("R2 rearm clears flag", timeout_o, 0);
        chk("R6 pulse survives rearm", sys_rst_n_o, 0);
        tick_once();
        chk("R6 pulse held", sys_rst_n_o, 0);
        chk("R4 count after rearm", count_o, 4);
        tick_once();
        chk("R6 pulse ends on schedule", sys_rst_n_o, 1);
        chk("R4 still running", running_o, 1);

        // R9 disarm
        en_write(1'b0);
        chk("R9 stopped", running_o, 0);
        repeat (6) tick_once();
        chk("R9 no timeout", timeout_o, 0);
        chk("R9 no pulse", sys_rst_n_o, 1);
        chk("R9 readback depth", count_o, 5);

        // R10 arm beats tick in the same cycle
        depth_i = 7'd2;
        @(negedge clk) begin en_wr_i = 1'b1; en_wdata_i = 1'b1; tick_i = 1'b1; end
        @(negedge clk) begin en_wr_i = 1'b0; tick_i = 1'b0; end
        chk("R10 arm over tick", count_o, 2);
        tick_once();
        chk("R10 count", count_o, 1);

        // R10 recovery beats configuration write at expiry
        safe_sel_i = 1'b1;
        safe_code_i = 5'd12;
        @(negedge clk) begin
            tick_i = 1'b1; cfg_wr_i = 1'b1; cfg_ssel_i = 5'd6;
            cfg_sw_en_i = 1'b1; cfg_mn_en_i = 1'b1;
        end
        @(negedge clk) begin tick_i = 1'b0; cfg_wr_i = 1'b0; end
        chk("R10 recovered code", freq_code_o, 12);
        chk("R10 mn cleared", mn_en_o, 0);
        chk("R10 timeout", timeout_o, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule